// File: doc/BRIEF.md
# High-Order Address Input Port

This block handles a small port of three pins plus one input that is always an input. Together they supply the upper address bits A16 to A19. Each of the three pins can instead be turned into an output, in which case it drives one of three chip-select signals produced elsewhere. The fourth input cannot become an output and always carries A19.

Two global settings control what the block does with the pins that are inputs:

- **Capture mode.** The values are either captured on the falling edge of the address strobe or passed straight through.
- **Role.** The values are either forwarded as address bits to the memory bank selection or offered only as plain logic inputs to a programmable decoder.

In logic-only role the address path sees all zeros. The falling edge of the strobe is found in the system clock domain.

Top module: `hiaddr_port`

## Requirements
- R1: A synchronous active-high reset clears all four captured bits to zero. With capture mode selected and every pin an input, `addr_out` and `logic_out` then read 0 until the first strobe fall.
- R2: For each pin i in 0..2, `cfg_dir[i]`=1 makes it an output. Then `pad_oe[i]`=1 and `pad_out[i]`=`cs_sel[i]`. For an input pin, `pad_oe[i]`=0 and `pad_out[i]`=0.
- R3: With `cfg_latch`=0 (transparent), the effective values follow the pad inputs combinationally in the same cycle.
- R4: With `cfg_latch`=1, the block captures the inputs at a clock edge where `strobe` is sampled low after being sampled high at the previous edge. The captured value appears at the outputs right after that edge. A rising strobe captures nothing.
- R5: Between strobe falls, captured bits hold their value whatever the pads do.
- R6: With `cfg_addr`=0, `addr_out` is all zeros, while `logic_out` still carries the effective values.
- R7: With `cfg_addr`=1, `addr_out` equals the effective values. Bits 0, 1 and 2 come from pins 0, 1 and 2 (A16 to A18), and bit 3 comes from `a19_in` (A19).
- R8: A pin set as output reads 0 in both `addr_out` and `logic_out`. Its captured bit ignores strobe falls and keeps its old value, which shows again once the pin returns to input in capture mode.
- R9: Bit 3 is always an input, is captured on every strobe fall in capture mode, and is never affected by `cfg_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Address strobe; its falling edge captures the inputs |
| pin_in | input | 3 | Values read from the three configurable pads |
| a19_in | input | 1 | Shared input carrying A19 |
| cfg_dir | input | 3 | Per-pin direction, 1 = chip-select output |
| cfg_latch | input | 1 | 1 = capture on strobe fall, 0 = transparent |
| cfg_addr | input | 1 | 1 = address role, 0 = logic-input role |
| cs_sel | input | 3 | Chip-select values to drive on output pins |
| pad_out | output | 3 | Pad output values |
| pad_oe | output | 3 | Pad output enables |
| addr_out | output | 4 | A19..A16 toward memory bank selection |
| logic_out | output | 4 | Effective input values toward the decoder |

## Verification
The only internal state is the four captured bits and the previous strobe sample. A wrong captured bit shows on `addr_out` and `logic_out` in the first cycle after the strobe fall that should have loaded it, provided capture mode is on and the pin is an input. A wrong strobe history shows as a capture one edge early or late, or as a capture on a rising edge. The bench therefore checks the outputs one edge after each fall, and again after the pads have changed without a fall. A captured bit that is corrupted while its pin is an output stays hidden until the pin returns to input. The bench includes that sequence.

// File: rtl/hiaddr_port.sv
module hiaddr_port #(
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [NPIN-1:0] pin_in,
  input  logic            a19_in,
  input  logic [NPIN-1:0] cfg_dir,
  input  logic            cfg_latch,
  input  logic            cfg_addr,
  input  logic [NPIN-1:0] cs_sel,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN:0]   addr_out,
  output logic [NPIN:0]   logic_out
);
  localparam int NB = NPIN + 1;

  logic          strobe_q;
  logic          fall;
  logic [NB-1:0] cap;
  logic [NB-1:0] raw;
  logic [NB-1:0] in_mask;
  logic [NB-1:0] eff;

  assign raw     = {a19_in, pin_in};
  assign in_mask = {1'b1, ~cfg_dir};
  assign fall    = strobe_q & ~strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      cap      <= '0;
    end else begin
      strobe_q <= strobe;
      if (fall)
        cap <= (raw & in_mask) | (cap & ~in_mask);
    end
  end

  assign eff       = (cfg_latch ? cap : raw) & in_mask;
  assign logic_out = eff;
  assign addr_out  = cfg_addr ? eff : '0;
  assign pad_oe    = cfg_dir;
  assign pad_out   = cs_sel & cfg_dir;

  a_r5_hold_no_fall: assert property (@(posedge clk) disable iff (rst)
    !(strobe_q && !strobe) |=> $stable(cap));
  a_r4_capture_a19: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && !strobe) |=> cap[NPIN] == $past(a19_in));
  a_r8_out_bit_keeps: assert property (@(posedge clk) disable iff (rst)
    cfg_dir[0] |=> cap[0] == $past(cap[0]));
  a_r6_logic_role_zero: assert property (@(posedge clk) disable iff (rst)
    !cfg_addr |-> addr_out == '0);
  a_r8_out_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (logic_out[NPIN-1:0] & cfg_dir) == '0);
  a_r2_idle_pad_low: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);
endmodule

// File: tb/test_hiaddr_port.sv
module test_hiaddr_port;
  logic       clk = 0;
  logic       rst = 1;
  logic       strobe = 0;
  logic [2:0] pin_in = 0;
  logic       a19_in = 0;
  logic [2:0] cfg_dir = 0;
  logic       cfg_latch = 1;
  logic       cfg_addr = 1;
  logic [2:0] cs_sel = 0;
  logic [2:0] pad_out, pad_oe;
  logic [3:0] addr_out, logic_out;

  int total = 0;
  int bad = 0;
  logic [3:0] m_cap = 0;

  always #2 clk = ~clk;

  hiaddr_port i_hiaddr_port (
    .clk(clk), .rst(rst), .strobe(strobe), .pin_in(pin_in), .a19_in(a19_in),
    .cfg_dir(cfg_dir), .cfg_latch(cfg_latch), .cfg_addr(cfg_addr), .cs_sel(cs_sel),
    .pad_out(pad_out), .pad_oe(pad_oe), .addr_out(addr_out), .logic_out(logic_out)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] mask_in(input logic [2:0] d);
    return {1'b1, ~d};
  endfunction

  task automatic set_pins(input logic [3:0] v);
    pin_in = v[2:0];
    a19_in = v[3];
  endtask

  task automatic check_latched(input string req);
    logic [3:0] e;
    e = m_cap & mask_in(cfg_dir);
    check(req, logic_out, e);
    check(req, addr_out, cfg_addr ? e : 4'b0);
  endtask

  task automatic pulse(input logic [3:0] v);
    @(negedge clk); set_pins(v); strobe = 1;
    @(negedge clk); strobe = 0;
    @(negedge clk);
    m_cap = (v & mask_in(cfg_dir)) | (m_cap & ~mask_in(cfg_dir));
    #1;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    set_pins(4'hF);
    @(negedge clk); rst = 0;
    #1;
    check("R1 logic after reset", logic_out, 4'h0);
    check("R1 addr after reset", addr_out, 4'h0);

    // R3 R6 R7 R9 R2 transparent sweep
    cfg_latch = 0;
    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 8; d++)
        for (int v = 0; v < 16; v++) begin
          logic [3:0] e;
          @(negedge clk);
          cfg_addr = a[0]; cfg_dir = d[2:0]; set_pins(v[3:0]);
          cs_sel = v[2:0] ^ d[2:0];
          #1;
          e = v[3:0] & mask_in(d[2:0]);
          check("R3/R8/R9 logic", logic_out, e);
          check(a ? "R7 addr" : "R6 addr zero", addr_out, a ? e : 4'b0);
          check("R2 oe", {1'b0, pad_oe}, {1'b0, d[2:0]});
          check("R2 pad", {1'b0, pad_out}, {1'b0, (v[2:0] ^ d[2:0]) & d[2:0]});
        end

    // R4 R5 latched mode
    cfg_latch = 1; cfg_dir = 0; cfg_addr = 1;
    for (int v = 0; v < 16; v++) begin
      pulse(v[3:0]);
      check_latched("R4 capture");
      set_pins(~v[3:0]); #1;
      check_latched("R5 hold after pad change");
    end

    // R4 rising edge alone captures nothing
    @(negedge clk); set_pins(4'h5); strobe = 1;
    @(negedge clk); @(negedge clk); #1;
    check_latched("R4 no capture on rise");
    @(negedge clk); set_pins(4'hA); #1;
    check_latched("R5 strobe high steady");
    @(negedge clk); strobe = 0;
    @(negedge clk); m_cap = 4'hA; #1;
    check_latched("R4 fall after long high");

    // R8 output pins keep their captured bits, R9 A19 still captured
    for (int d = 1; d < 8; d++) begin
      cfg_dir = 0;
      pulse(4'h0);
      cfg_dir = d[2:0];
      pulse(4'hF);
      check_latched("R8/R9 out pins read zero");
      @(negedge clk); cfg_dir = 0; #1;
      check("R8 kept bits after return", logic_out, {1'b1, ~d[2:0]});
    end

    // R6 role switch in latched mode
    cfg_dir = 0;
    pulse(4'h9);
    cfg_addr = 0; #1;
    check("R6 addr zero latched", addr_out, 4'h0);
    check("R6 logic latched", logic_out, 4'h9);

    // R1 reset clears capture
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; cfg_addr = 1; m_cap = 0; #1;
    check_latched("R1 second reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule